// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block sits between a set of external interrupt request lines and a processor core. For each line it keeps an enable bit, a pending bit, an active bit and a 4-bit urgency value. It continuously picks the most urgent pending, enabled line. It raises a request to the core only when that line is allowed to interrupt whatever handler is currently running.

A single group field divides every urgency value into two parts. The upper part is the preemption level and decides whether a running handler may be interrupted. The lower part, the sub-level, only takes part in ordering requests that are waiting. The core accepts a request with an acknowledge pulse and signals the end of a handler with a completion pulse. The block keeps a small last-in first-out record of nested handlers, so that each completion retires the handler entered most recently.

Software reaches the state through a word-addressed register port. Enable and pending bits each have separate set and clear banks with write-one semantics. The active bits can be read but not written. Urgency values are packed four per word. The group word only accepts writes that carry a fixed key.

Top module: `grouped_irq_arbiter`

## Requirements
- R1: After synchronous reset, every enable, pending and active bit is 0, every urgency value is 0, the stored group field is 0 and irq_req is low.
- R2: Line k maps to bank word k/32, bit k mod 32. Enable bits are set by writing ones to word address 0x00+w and cleared by writing ones to 0x08+w. Zero bits have no effect, and a read of either address returns the enable bits.
- R3: Pending bits are set through 0x10+w and cleared through 0x18+w with write-one semantics, and reads return the pending bits. A high level on irq_in[k] sets pending bit k on each clock edge. Within one edge, clears (by write or acknowledge) take precedence over sets.
- R4: The urgency of line n is written at word address 0x40+n/4 in byte n mod 4. Only the upper nibble of the byte is stored, and the lower nibble reads as zero.
- R5: The group word at 0x80 is updated only when wdata[31:16] equals 0x05FA. Bits 10:8 store a field f, and a read returns f in bits 10:8 with all other bits zero. The number of preemption bits is min(7−f, 4), taken from the top of the urgency value.
- R6: Among lines that are both pending and enabled, the candidate is the one with the smallest urgency value, with the lowest line number winning a tie. Pending lines that are not enabled are never presented.
- R7: With no handler active, irq_req is high and irq_id holds the candidate from the second clock edge after the candidate's state was written.
- R8: While a handler is active, a request is raised only if the candidate's preemption part is strictly smaller than that of the most recently entered handler. An equal preemption part with a smaller sub-level never raises a request.
- R9: On an edge where cpu_ack is high while irq_req is high, the pending bit of irq_id clears, its active bit sets, and irq_req is low after that edge.
- R10: A cpu_done pulse clears the active bit of the most recently entered handler only. The preemption level in force falls back to the handler entered before it.
- R11: The active bank at 0x20+w is read-only, and writes to it leave the active bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Level-sensitive external request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Word address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the address of the previous cycle |
| irq_req | output | 1 | Request to the core to enter a handler |
| irq_id | output | $clog2(NUM_IRQ) | Line number offered with irq_req |
| cpu_ack | input | 1 | Core accepts the offered line |
| cpu_done | input | 1 | Core completes the innermost handler |

## Verification
The checker watches on every cycle that an accepted request drops irq_req and moves the offered line from pending to active. It also checks that a completion retires exactly the innermost handler, that the number of active bits always equals the nesting depth, and that reset leaves no request and no active handler. Which line wins, and whether an equal preemption part with a better sub-level stays silent, depend on programmed urgency values and on the group field. Those are shown only by the bench's scenarios, which step through several group settings, tie breaks, masked lines and two-level nesting. The bench also covers the register semantics: write-one set and clear, key rejection, nibble packing and the read-only active bank.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int PRIO_W  = 4;
  localparam int ADDR_W  = 8;
  localparam logic [15:0] GRP_KEY = 16'h05FA;

  // word address map
  localparam int A_SETEN = 'h00;
  localparam int A_CLREN = 'h08;
  localparam int A_SETPD = 'h10;
  localparam int A_CLRPD = 'h18;
  localparam int A_ACTV  = 'h20;
  localparam int A_PRIO  = 'h40;
  localparam int A_GRP   = 'h80;

  // mask selecting the preemption bits for a stored (inverted) group field
  function automatic logic [PRIO_W-1:0] pre_mask(input logic [2:0] fld);
    int g;
    g = 7 - int'(fld);
    if (g > PRIO_W) g = PRIO_W;
    return ~({PRIO_W{1'b1}} >> g);
  endfunction
endpackage

// File: rtl/irqarb_regs.sv
module irqarb_regs
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int IDW    = $clog2(NUM_IRQ),
  localparam int WORDS  = NUM_IRQ / 32,
  localparam int PWORDS = NUM_IRQ / 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IRQ-1:0]       irq_in,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     ack_fire,
  input  logic [IDW-1:0]           ack_id,
  input  logic [NUM_IRQ-1:0]       active_vec,
  output logic [NUM_IRQ-1:0]       en_vec,
  output logic [NUM_IRQ-1:0]       pend_vec,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic [2:0]               grp_field
);
  logic [NUM_IRQ-1:0] en_q, pend_q;
  logic [NUM_IRQ-1:0] en_set, en_clr, pd_set, pd_clr, ack_mask;
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic [2:0]         grp_q;
  logic [31:0]        rd_next;
  int                 a;

  assign a = int'(reg_addr);

  // write decode of the bit banks
  always_comb begin
    en_set = '0; en_clr = '0; pd_set = '0; pd_clr = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (reg_we && a == A_SETEN + w) en_set[w*32 +: 32] = reg_wdata;
      if (reg_we && a == A_CLREN + w) en_clr[w*32 +: 32] = reg_wdata;
      if (reg_we && a == A_SETPD + w) pd_set[w*32 +: 32] = reg_wdata;
      if (reg_we && a == A_CLRPD + w) pd_clr[w*32 +: 32] = reg_wdata;
    end
    ack_mask = '0;
    if (ack_fire) ack_mask[ack_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      grp_q  <= '0;
    end else begin
      en_q   <= (en_q | en_set) & ~en_clr;
      pend_q <= (pend_q | pd_set | irq_in) & ~(pd_clr | ack_mask);
      if (reg_we && a == A_GRP && reg_wdata[31:16] == GRP_KEY)
        grp_q <= reg_wdata[10:8];
    end
  end

  // urgency nibbles, four per word, upper nibble of each byte
  always_ff @(posedge clk) begin
    for (int n = 0; n < NUM_IRQ; n++) begin
      if (rst)
        prio_q[n] <= '0;
      else if (reg_we && a == A_PRIO + n / 4)
        prio_q[n] <= reg_wdata[(n % 4)*8 + 4 +: PRIO_W];
    end
  end

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (a == A_SETEN + w || a == A_CLREN + w) rd_next = en_q[w*32 +: 32];
      if (a == A_SETPD + w || a == A_CLRPD + w) rd_next = pend_q[w*32 +: 32];
      if (a == A_ACTV + w)                      rd_next = active_vec[w*32 +: 32];
    end
    for (int j = 0; j < PWORDS; j++) begin
      if (a == A_PRIO + j)
        for (int b = 0; b < 4; b++) rd_next[b*8 + 4 +: PRIO_W] = prio_q[j*4 + b];
    end
    if (a == A_GRP) rd_next[10:8] = grp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++) prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n];
  end

  assign en_vec    = en_q;
  assign pend_vec  = pend_q;
  assign grp_field = grp_q;
endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  localparam int IDW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        cand,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      win_valid,
  output logic [IDW-1:0]            win_id,
  output logic [PRIO_W-1:0]         win_prio
);
  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqarb_nest.sv
module irqarb_nest #(
  parameter int NUM_IRQ = 64,
  parameter int DEPTH   = 16,
  localparam int IDW   = $clog2(NUM_IRQ),
  localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [IDW-1:0]     push_id,
  input  logic               pop,
  output logic [NUM_IRQ-1:0] active_vec,
  output logic               top_valid,
  output logic [IDW-1:0]     top_id,
  output logic [CNT_W-1:0]   cnt
);
  logic [IDW-1:0]     stk [DEPTH];
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_IRQ-1:0] act_q, act_n;
  logic [SW-1:0]      top_slot, wr_slot;
  logic               pop_ok, push_ok;

  assign top_slot  = SW'(cnt_q - 1'b1);
  assign top_valid = (cnt_q != '0);
  assign top_id    = top_valid ? stk[top_slot] : '0;
  assign pop_ok    = pop && top_valid;
  assign push_ok   = push && ((cnt_q < CNT_W'(DEPTH)) || pop_ok);
  assign wr_slot   = pop_ok ? top_slot : SW'(cnt_q);

  always_comb begin
    act_n = act_q;
    if (pop_ok)  act_n[top_id]  = 1'b0;
    if (push_ok) act_n[push_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      act_q <= act_n;
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) stk[wr_slot] <= push_id;
  end

  assign active_vec = act_q;
  assign cnt        = cnt_q;
endmodule

// File: rtl/grouped_irq_arbiter.sv
module grouped_irq_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_IRQ    = 64,
  parameter int NEST_DEPTH = 16,
  localparam int IDW   = $clog2(NUM_IRQ),
  localparam int CNT_W = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_req,
  output logic [IDW-1:0]     irq_id,
  input  logic               cpu_ack,
  input  logic               cpu_done
);
  logic [NUM_IRQ-1:0]        en_vec, pend_vec, active_vec;
  logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
  logic [2:0]                grp_field;
  logic                      win_valid, top_valid, ack_fire, allow;
  logic [IDW-1:0]            win_id, top_id;
  logic [PRIO_W-1:0]         win_prio, top_prio, pmask;
  logic [CNT_W-1:0]          nest_cnt;
  logic                      req_q;
  logic [IDW-1:0]            id_q;

  assign ack_fire = cpu_ack && req_q;

  irqarb_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_fire(ack_fire), .ack_id(id_q), .active_vec(active_vec),
    .en_vec(en_vec), .pend_vec(pend_vec), .prio_flat(prio_flat), .grp_field(grp_field)
  );

  irqarb_select #(.NUM_IRQ(NUM_IRQ)) u_sel (
    .cand(en_vec & pend_vec), .prio_flat(prio_flat),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  irqarb_nest #(.NUM_IRQ(NUM_IRQ), .DEPTH(NEST_DEPTH)) u_nest (
    .clk(clk), .rst(rst), .push(ack_fire), .push_id(id_q), .pop(cpu_done),
    .active_vec(active_vec), .top_valid(top_valid), .top_id(top_id), .cnt(nest_cnt)
  );

  // preemption decision on the masked upper part only
  assign pmask    = pre_mask(grp_field);
  assign top_prio = prio_flat[int'(top_id)*PRIO_W +: PRIO_W];
  assign allow    = win_valid && (!top_valid || ((win_prio & pmask) < (top_prio & pmask)));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      id_q  <= '0;
    end else begin
      req_q <= ack_fire ? 1'b0 : allow;
      if (!ack_fire) id_q <= win_id;
    end
  end

  assign irq_req = req_q;
  assign irq_id  = id_q;
endmodule

// File: rtl/irqarb_chk.sv
module irqarb_chk #(
  parameter int NUM_IRQ    = 64,
  parameter int NEST_DEPTH = 16,
  localparam int IDW   = $clog2(NUM_IRQ),
  localparam int CNT_W = $clog2(NEST_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_req,
  input logic [IDW-1:0]     irq_id,
  input logic               cpu_ack,
  input logic               cpu_done,
  input logic [NUM_IRQ-1:0] pend_vec,
  input logic [NUM_IRQ-1:0] active_vec,
  input logic [CNT_W-1:0]   nest_cnt,
  input logic [IDW-1:0]     top_id
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_req && active_vec == '0));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_req) |=> !irq_req);

  // R9
  ack_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && irq_req && !cpu_done) |=>
      (active_vec[$past(irq_id)] && !pend_vec[$past(irq_id)]));

  // R10
  done_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && nest_cnt != '0 && !cpu_ack) |=> !active_vec[$past(top_id)]);

  // R10
  nest_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(active_vec) == int'(nest_cnt));
endmodule

bind grouped_irq_arbiter irqarb_chk #(.NUM_IRQ(NUM_IRQ), .NEST_DEPTH(NEST_DEPTH)) i_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_id(irq_id),
  .cpu_ack(cpu_ack), .cpu_done(cpu_done), .pend_vec(pend_vec),
  .active_vec(active_vec), .nest_cnt(nest_cnt), .top_id(top_id)
);

// File: tb/test_grouped_irq_arbiter.sv
module test_grouped_irq_arbiter;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic [5:0]  irq_id;
  logic        cpu_ack = 1'b0;
  logic        cpu_done = 1'b0;

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  grouped_irq_arbiter #(.NUM_IRQ(N), .NEST_DEPTH(16)) i_grouped_irq_arbiter (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_id(irq_id),
    .cpu_ack(cpu_ack), .cpu_done(cpu_done)
  );

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [14] = '{
    {8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0},  // R2 set
    {8'h00, 32'h0000_0000, 8'h08, 32'h0000_00F0},  // R2 zero no effect
    {8'h08, 32'h0000_0030, 8'h00, 32'h0000_00C0},  // R2 clear
    {8'h01, 32'h8000_0001, 8'h09, 32'h8000_0001},  // R2 lines 32 and 63
    {8'h09, 32'hFFFF_FFFF, 8'h01, 32'h0000_0000},  // R2
    {8'h08, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000},  // R2
    {8'h41, 32'h1234_5678, 8'h41, 32'h1030_5070},  // R4 upper nibbles
    {8'h41, 32'h0000_0000, 8'h41, 32'h0000_0000},  // R4
    {8'h80, 32'h0000_0700, 8'h80, 32'h0000_0000},  // R5 missing key
    {8'h80, 32'h05FA_0300, 8'h80, 32'h0000_0300},  // R5 keyed
    {8'h80, 32'h05FA_0000, 8'h80, 32'h0000_0000},  // R5
    {8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0000_0000},  // R11
    {8'h10, 32'h0000_0001, 8'h10, 32'h0000_0001},  // R3 set
    {8'h18, 32'h0000_0001, 8'h18, 32'h0000_0000}   // R3 clear
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); cpu_done = 1'b1;
    @(negedge clk); cpu_done = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq_req", {31'b0, irq_req}, 32'h0);
    rd(8'h00, rv); check("R1 enable", rv, 32'h0);
    rd(8'h10, rv); check("R1 pending", rv, 32'h0);
    rd(8'h20, rv); check("R1 active", rv, 32'h0);
    rd(8'h80, rv); check("R1 group", rv, 32'h0);
    rd(8'h4F, rv); check("R1 urgency", rv, 32'h0);

    for (int i = 0; i < 14; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], rv);
      check($sformatf("table vector %0d (R2/R3/R4/R5/R11)", i), rv, VEC[i][31:0]);
    end

    // two preemption bits: f=5
    wr(8'h80, 32'h05FA_0500);
    wr(8'h41, 32'h0000_8000);  // line 5  -> 8
    wr(8'h42, 32'h0000_8000);  // line 9  -> 8
    wr(8'h43, 32'h0000_0050);  // line 12 -> 5
    wr(8'h4A, 32'h0000_0060);  // line 40 -> 6
    wr(8'h4C, 32'h0020_0000);  // line 50 -> 2
    wr(8'h00, 32'h0000_1220);
    wr(8'h01, 32'h0004_0100);

    wr(8'h10, 32'h0000_0220);
    idle(3);
    check("R7 request raised", {31'b0, irq_req}, 32'h1);
    check("R6 tie lowest id", {26'b0, irq_id}, 32'd5);

    wr(8'h11, 32'h0000_0100);
    idle(3);
    check("R6 smallest urgency", {26'b0, irq_id}, 32'd40);

    ack_pulse();
    check("R9 req drops", {31'b0, irq_req}, 32'h0);
    rd(8'h21, rv); check("R9 active set", rv, 32'h0000_0100);
    rd(8'h11, rv); check("R9 pending cleared", rv, 32'h0);

    wr(8'h21, 32'hFFFF_FFFF);
    rd(8'h21, rv); check("R11 active read-only", rv, 32'h0000_0100);

    wr(8'h10, 32'h0000_1000);  // line 12: same preemption part, better sub-level
    idle(3);
    check("R8 no preempt on sub-level", {31'b0, irq_req}, 32'h0);

    wr(8'h11, 32'h0004_0000);  // line 50
    idle(3);
    check("R8 preempt raised", {31'b0, irq_req}, 32'h1);
    check("R8 preempt id", {26'b0, irq_id}, 32'd50);
    ack_pulse();
    rd(8'h21, rv); check("R9 nested active", rv, 32'h0004_0100);

    done_pulse();
    rd(8'h21, rv); check("R10 innermost retired", rv, 32'h0000_0100);
    idle(3);
    check("R10 level restored to outer", {31'b0, irq_req}, 32'h0);
    done_pulse();
    rd(8'h21, rv); check("R10 outer retired", rv, 32'h0);
    idle(3);
    check("R10 request after unwinding", {31'b0, irq_req}, 32'h1);
    check("R10 winner after unwinding", {26'b0, irq_id}, 32'd12);

    // no preemption bits: f=7
    wr(8'h80, 32'h05FA_0700);
    ack_pulse();
    wr(8'h11, 32'h0004_0000);
    idle(3);
    check("R5 zero preemption bits", {31'b0, irq_req}, 32'h0);
    wr(8'h80, 32'h05FA_0300);
    idle(3);
    check("R5 four preemption bits", {31'b0, irq_req}, 32'h1);
    check("R5 four preemption bits id", {26'b0, irq_id}, 32'd50);

    // level input on a disabled line
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in[3] = 1'b0;
    rd(8'h10, rv); check("R3 level sets pending", rv, 32'h0000_0228);
    idle(2);
    check("R6 disabled line ignored", {26'b0, irq_id}, 32'd50);
    @(negedge clk); irq_in[3] = 1'b1;
    wr(8'h18, 32'h0000_0008);
    irq_in[3] = 1'b0;
    rd(8'h10, rv); check("R3 clear wins over level", rv, 32'h0000_0220);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule